// File: doc/BRIEF.md
# Supply Loss Supervisor with Memory Write Protect

This block guards a battery-backed memory across loss and return of the main supply. It watches two digital comparator flags. One says the supply has sagged below the deselect trip level. The other says it has fallen below the level where the memory has to run from its cell. From these flags it runs a fixed sequence. First it raises an early-warning interrupt. After a bounded delay, counted in microsecond ticks, it cuts the memory off. While the supply is very low it selects the battery. When the supply comes back, it holds the memory protected for a fixed recovery period.

While the block protects the memory, it gates the host's memory strobes: chip select, write strobe and output drive are all forced inactive. The memory cannot be written, and it does not drive the data bus. The interrupt is modelled as a pull-down enable for an open-drain line, so the block can only pull the line low and never drives it high. Both comparator flags are asynchronous and pass through a synchronizer of `SYNC_STAGES` flops before they are used. The analog sensing, the power switch and the memory array lie outside the block.

Top module: `pwrfail_supervisor`

## Requirements
- R1: When `vcc_below_trip` goes high, `irq_pull` goes high exactly `SYNC_STAGES` (default 2) clock edges later, while `mem_protect` is still low.
- R2: After the warning begins, `mem_protect` rises on the clock edge that samples the `DESEL_TICKS`-th `us_tick` pulse (default 25), and not on any earlier one.
- R3: If `vcc_below_trip` clears before the deselect delay has run out, `irq_pull` drops, `mem_protect` never rises, and the next warning starts its tick count from zero.
- R4: While `mem_protect` is 1, `mem_cs`, `mem_we` and `dq_drive` are all 0, whatever the host strobes are.
- R5: While `mem_protect` is 0, `mem_cs` equals `host_cs`, `mem_we` equals `host_cs & host_we`, and `dq_drive` equals `host_cs & host_oe & ~host_we`. A write strobe therefore turns off output drive.
- R6: `bat_sel` follows `vcc_below_swo` `SYNC_STAGES` clock edges later, both when the flag rises and when it falls.
- R7: After `vcc_below_trip` clears, `irq_pull` drops `SYNC_STAGES` edges later. `mem_protect` stays at 1 until the `RECOV_TICKS`-th `us_tick` (default 1000) after the synchronized flag clears, and falls on that tick.
- R8: If `vcc_below_trip` returns during the recovery period, the period is abandoned. After the flag clears again, a full `RECOV_TICKS` count is needed.
- R9: After reset, `mem_protect` is 1, `irq_pull` is 0 and `bat_sel` is 0. The memory stays protected until a full `RECOV_TICKS` count has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| vcc_below_trip | input | 1 | Comparator flag: supply below deselect trip level (asynchronous) |
| vcc_below_swo | input | 1 | Comparator flag: supply below battery switchover level (asynchronous) |
| host_cs | input | 1 | Host memory chip select, active high |
| host_we | input | 1 | Host memory write strobe, active high |
| host_oe | input | 1 | Host memory output enable, active high |
| irq_pull | output | 1 | 1 = pull the open-drain interrupt line low |
| mem_protect | output | 1 | 1 = memory deselected and write protected |
| bat_sel | output | 1 | 1 = memory powered from the battery |
| mem_cs | output | 1 | Gated chip select to the memory |
| mem_we | output | 1 | Gated write strobe to the memory |
| dq_drive | output | 1 | Gated enable for the memory data output drivers |

## Verification
The bench counts `us_tick` pulses right up to both delay limits. A counter that is off by one would protect the memory a tick too early, or release it a tick too late, and one of the checks at N-1 or N would catch that. It lets a warning lapse and then starts a new one, and it brings the trip flag back in the middle of recovery. A counter that is not cleared between attempts would then deselect early, or release the memory before a full recovery period. The strobe table is walked once with the memory enabled and once with it protected, so a gate that leaks a write, or drives the bus during a write, shows up. The battery select is timed on both edges of its flag.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    PFS_RECOVER = 2'd0,
    PFS_NORMAL  = 2'd1,
    PFS_WARN    = 2'd2,
    PFS_DOWN    = 2'd3
  } pfs_state_e;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pfs_tick_counter.sv
module pfs_tick_counter #(
  parameter int LIMIT = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (tick_i) begin
      if (cnt_q == LAST)        cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = tick_i && !clr_i && (cnt_q == LAST);

  // R2 / R7: the count never passes its limit
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
  import pfs_pkg::*;
#(
  parameter int DESEL_TICKS = 25,
  parameter int RECOV_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic trip_i,
  output logic protect_o
);
  pfs_state_e state_q, state_d;
  logic warn_done, rec_done;
  logic warn_clr, rec_clr;

  assign warn_clr = (state_q != PFS_WARN) || !trip_i;
  assign rec_clr  = (state_q != PFS_RECOVER) || trip_i;

  pfs_tick_counter #(.LIMIT(DESEL_TICKS)) u_warn_ctr (
    .clk(clk), .rst_n(rst_n), .clr_i(warn_clr), .tick_i(tick_i), .done_o(warn_done)
  );

  pfs_tick_counter #(.LIMIT(RECOV_TICKS)) u_rec_ctr (
    .clk(clk), .rst_n(rst_n), .clr_i(rec_clr), .tick_i(tick_i), .done_o(rec_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PFS_RECOVER: if (trip_i) state_d = PFS_DOWN;
                   else if (rec_done) state_d = PFS_NORMAL;
      PFS_NORMAL:  if (trip_i) state_d = PFS_WARN;
      PFS_WARN:    if (!trip_i) state_d = PFS_NORMAL;
                   else if (warn_done) state_d = PFS_DOWN;
      PFS_DOWN:    if (!trip_i) state_d = PFS_RECOVER;
      default:     state_d = PFS_RECOVER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PFS_RECOVER;
    else        state_q <= state_d;
  end

  assign protect_o = (state_q == PFS_DOWN) || (state_q == PFS_RECOVER);

  // R7: release only on a tick with the supply flag clear
  a_r7_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(protect_o) |-> ($past(tick_i) && !$past(trip_i)));
endmodule

// File: rtl/pfs_gate.sv
module pfs_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic protect_i,
  input  logic cs_i,
  input  logic we_i,
  input  logic oe_i,
  output logic cs_o,
  output logic we_o,
  output logic drive_o
);
  logic open_w;
  assign open_w  = !protect_i && cs_i;
  assign cs_o    = open_w;
  assign we_o    = open_w && we_i;
  assign drive_o = open_w && oe_i && !we_i;

  // R4: no strobe reaches the memory while protected
  a_r4_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    protect_i |-> !(cs_o || we_o || drive_o));
  // R5: never drive the bus during a write
  a_r5_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> !drive_o);
endmodule

// File: rtl/pwrfail_supervisor.sv
module pwrfail_supervisor #(
  parameter int SYNC_STAGES = 2,
  parameter int DESEL_TICKS = 25,
  parameter int RECOV_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic vcc_below_trip,
  input  logic vcc_below_swo,
  input  logic host_cs,
  input  logic host_we,
  input  logic host_oe,
  output logic irq_pull,
  output logic mem_protect,
  output logic bat_sel,
  output logic mem_cs,
  output logic mem_we,
  output logic dq_drive
);
  logic [1:0] flags_s;
  logic       trip_s;

  pfs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({vcc_below_swo, vcc_below_trip}),
    .q_o(flags_s)
  );

  assign trip_s   = flags_s[0];
  assign bat_sel  = flags_s[1];
  assign irq_pull = trip_s;

  pfs_fsm #(.DESEL_TICKS(DESEL_TICKS), .RECOV_TICKS(RECOV_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick_i(us_tick), .trip_i(trip_s),
    .protect_o(mem_protect)
  );

  pfs_gate u_gate (
    .clk(clk), .rst_n(rst_n), .protect_i(mem_protect),
    .cs_i(host_cs), .we_i(host_we), .oe_i(host_oe),
    .cs_o(mem_cs), .we_o(mem_we), .drive_o(dq_drive)
  );

  // R1 / R2: the memory is cut off only after the warning is already out
  a_r2_irq_before_protect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_protect) |-> $past(irq_pull));
endmodule

// File: tb/pwrfail_supervisor_bench.sv
module pwrfail_supervisor_bench;
  localparam int SYNC  = 2;
  localparam int DESEL = 25;
  localparam int RECOV = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0, trip = 1'b0, swo = 1'b0;
  logic hcs = 1'b0, hwe = 1'b0, hoe = 1'b0;
  logic irq_pull, mem_protect, bat_sel, mem_cs, mem_we, dq_drive;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwrfail_supervisor #(.SYNC_STAGES(SYNC), .DESEL_TICKS(DESEL), .RECOV_TICKS(RECOV)) u_pwrfail_supervisor (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .vcc_below_trip(trip), .vcc_below_swo(swo),
    .host_cs(hcs), .host_we(hwe), .host_oe(hoe),
    .irq_pull(irq_pull), .mem_protect(mem_protect), .bat_sel(bat_sel),
    .mem_cs(mem_cs), .mem_we(mem_we), .dq_drive(dq_drive)
  );

  // {cs, we, oe, exp_cs, exp_we, exp_drive} for the enabled memory
  localparam logic [5:0] VEC [8] = '{
    6'b000_000, 6'b001_000, 6'b010_000, 6'b011_000,
    6'b100_100, 6'b101_101, 6'b110_110, 6'b111_110
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) us_tick = 1'b1;
      @(negedge clk) us_tick = 1'b0;
    end
  endtask

  task automatic walk_table(input bit prot, input string req);
    for (int i = 0; i < 8; i++) begin
      {hcs, hwe, hoe} = VEC[i][5:3];
      #1;
      check(req, {1'b0, mem_cs, mem_we, dq_drive}, prot ? 4'b0000 : {1'b0, VEC[i][2:0]});
    end
    {hcs, hwe, hoe} = 3'b000;
  endtask

  initial begin
    cyc(3);
    // R9: reset state
    check("R9 reset", {1'b0, mem_protect, irq_pull, bat_sel}, 4'b0100);
    rst_n = 1'b1;
    cyc(1);
    walk_table(1'b1, "R4 protected after reset");
    cyc(3);
    ticks(RECOV - 1);
    cyc(1);
    check("R9 still protected at N-1", {3'b0, mem_protect}, 4'b0001);
    ticks(1);
    check("R9 release at N", {3'b0, mem_protect}, 4'b0000);
    walk_table(1'b0, "R5 gate normal");

    // R1 warning
    trip = 1'b1;
    cyc(1);
    check("R1 irq not before sync", {3'b0, irq_pull}, 4'b0000);
    cyc(1);
    check("R1 irq asserted", {2'b0, irq_pull, mem_protect}, 4'b0010);
    cyc(1);
    ticks(DESEL - 1);
    check("R2 no protect at N-1", {2'b0, irq_pull, mem_protect}, 4'b0010);
    // R3 abort
    trip = 1'b0;
    cyc(3);
    check("R3 abort clears irq", {2'b0, irq_pull, mem_protect}, 4'b0000);
    ticks(3);
    check("R3 no late deselect", {3'b0, mem_protect}, 4'b0000);
    trip = 1'b1;
    cyc(3);
    ticks(DESEL - 1);
    check("R3 count restarted", {2'b0, irq_pull, mem_protect}, 4'b0010);
    ticks(1);
    check("R2 protect at N", {2'b0, irq_pull, mem_protect}, 4'b0011);
    walk_table(1'b1, "R4 gate protected");

    // R6 battery select
    swo = 1'b1;
    cyc(1);
    check("R6 bat not before sync", {3'b0, bat_sel}, 4'b0000);
    cyc(1);
    check("R6 bat on", {3'b0, bat_sel}, 4'b0001);
    swo = 1'b0;
    cyc(1);
    check("R6 bat held one edge", {3'b0, bat_sel}, 4'b0001);
    cyc(1);
    check("R6 bat off", {3'b0, bat_sel}, 4'b0000);

    // R7 / R8 recovery
    trip = 1'b0;
    cyc(2);
    check("R7 irq released", {2'b0, irq_pull, mem_protect}, 4'b0001);
    cyc(2);
    ticks(RECOV / 2);
    trip = 1'b1;
    cyc(4);
    check("R8 glitch irq", {2'b0, irq_pull, mem_protect}, 4'b0011);
    trip = 1'b0;
    cyc(4);
    ticks(RECOV - 1);
    check("R8 full count needed", {3'b0, mem_protect}, 4'b0001);
    ticks(1);
    check("R7 release at N", {2'b0, irq_pull, mem_protect}, 4'b0000);
    walk_table(1'b0, "R5 gate after recovery");

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule